// File: doc/BRIEF.md
# Fixed-Codebook Key Quantizer Encoder

This block turns one key vector into the compact form kept in a key cache: a scalar magnitude and one short index per coordinate. It takes two views of the same key. The untransformed coordinates are used only to find the Euclidean length. The coordinates that have already passed through the rotation unit are binned against a small threshold table. That table is fixed when the design is built and depends only on the vector length and the index width, so every layer and head uses the same few constants.

Coordinates are never divided by the length. Each threshold is multiplied by the length once per key, and every rotated coordinate is then compared against the scaled set. Apart from the sum of squares and that single scaling step, the encoder uses only comparators. When the packed indices and the length are ready, the block raises a one-cycle write strobe with the token address that came with the key.

A key is taken when `start_i` is high and the encoder is idle. The write appears a fixed number of cycles later. A start that arrives while a key is in flight is dropped.

Top module: `kq_encoder`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first write, `wr_en_o`, `addr_o`, `norm_o` and `idx_o` are all zero.
- R2: A key is accepted on a rising edge where `start_i` is high and the encoder is idle. Exactly NORM_W+2 edges later (12 with defaults), `wr_en_o` is high for exactly one cycle and `addr_o` carries the `addr_i` value sampled at acceptance.
- R3: `norm_o` equals floor(sqrt(sum over i of k_i squared)), where k_i is the two's-complement coordinate i of `key_raw_i`.
- R4: The codebook holds 2^BITS−1 signed thresholds T_j in units of 1/256. For BITS=3 they are {−447, −269, −128, 0, 128, 269, 447}. For BITS=2 they are {−251, 0, 251}. For each key the scaled threshold is S_j = floor(norm·T_j / 2^(8+log2(DIM)/2)), with DIM a power of four. The scaled set is ascending and its middle entry is 0.
- R5: The index of a rotated coordinate x is the number of S_j with x ≥ S_j, so a value equal to a threshold falls into the upper bin.
- R6: Coordinate i's index occupies `idx_o[i*BITS +: BITS]`, so coordinate 0 sits in the least significant bits.
- R7: A `start_i` pulse while a key is in flight causes no write and does not change the in-flight result. Key and address inputs are sampled only on the accepting edge.
- R8: For every coordinate, the top bit of its index is 1 exactly when the rotated coordinate is non-negative.
- R9: Between writes, `addr_o`, `norm_o` and `idx_o` hold the values of the last write.
- R10: With BITS=2 the same rules apply, using the 2-bit threshold set and 2-bit packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Present a key; taken only when idle |
| key_raw_i | input | DIM*COORD_W | Untransformed key, signed coordinates, coordinate 0 in the low bits |
| key_rot_i | input | DIM*COORD_W | Rotated key, signed coordinates, coordinate 0 in the low bits |
| addr_i | input | ADDR_W | Token position for the key |
| wr_en_o | output | 1 | One-cycle write strobe to the cache array |
| addr_o | output | ADDR_W | Write address |
| norm_o | output | NORM_W | Integer key length |
| idx_o | output | DIM*BITS | Packed codebook indices |

## Verification
On every cycle the assertions check four things. The write strobe lasts one cycle. The captured address stays fixed when a start arrives while busy. The outputs hold between writes. Each index's top bit agrees with the sign of its coordinate. When a key reaches its final stage, they also check that the scaled thresholds are ascending and centred on zero. The exact length, the exact bin counts at and around threshold ties, the packing order, the 12-cycle latency and the 2-bit variant can only be shown by the bench. It compares both widths against a behavioural model using zero, tie, full-scale and random keys, and it issues a start while a key is in flight.

// File: rtl/kq_pkg.sv
package kq_pkg;
  localparam int unsigned THR_FRAC = 8;
  localparam int unsigned THR_W    = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_SCALE, ST_EMIT} kq_state_e;

  // Optimal unit-variance decision levels, Q.8, mirrored about zero
  function automatic logic signed [THR_W-1:0] thr_rom(input int bits, input int j);
    int mid;
    int k;
    int mag;
    mid = (1 << (bits - 1)) - 1;
    k   = (j >= mid) ? (j - mid) : (mid - j);
    if (bits == 2) mag = (k == 0) ? 0 : 251;
    else begin
      case (k)
        0:       mag = 0;
        1:       mag = 128;
        2:       mag = 269;
        default: mag = 447;
      endcase
    end
    return (j < mid) ? THR_W'(-mag) : THR_W'(mag);
  endfunction
endpackage

// File: rtl/kq_sqrt.sv
module kq_sqrt #(
  parameter int IN_W  = 20,
  parameter int OUT_W = IN_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IN_W-1:0]  rad_i,
  output logic             done_o,
  output logic [OUT_W-1:0] root_o
);
  localparam int CNT_W = (OUT_W > 1) ? $clog2(OUT_W) : 1;

  logic [IN_W-1:0]  op_q, res_q, one_q, trial;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign trial  = res_q + one_q;
  assign done_o = run_q && (cnt_q == CNT_W'(OUT_W - 1));
  assign root_o = res_q[OUT_W-1:0];

  // one result bit per cycle, shift-subtract
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      res_q <= '0;
      one_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      op_q  <= rad_i;
      res_q <= '0;
      one_q <= IN_W'(1) << (IN_W - 2);
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (op_q >= trial) begin
        op_q  <= op_q - trial;
        res_q <= (res_q >> 1) + one_q;
      end else begin
        res_q <= res_q >> 1;
      end
      one_q <= one_q >> 2;
      cnt_q <= cnt_q + CNT_W'(1);
      if (done_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/kq_thresh_scale.sv
module kq_thresh_scale
  import kq_pkg::*;
#(
  parameter int BITS   = 3,
  parameter int NORM_W = 10,
  parameter int SHIFT  = 10,
  parameter int P_W    = NORM_W + 1 + THR_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic [NORM_W-1:0]              norm_i,
  output logic [((1<<BITS)-1)*P_W-1:0]   thr_o
);
  localparam int NT = (1 << BITS) - 1;

  logic signed [P_W-1:0] norm_ext;
  assign norm_ext = P_W'($signed({1'b0, norm_i}));

  for (genvar gj = 0; gj < NT; gj++) begin : g_thr
    localparam logic signed [THR_W-1:0] TV = thr_rom(BITS, gj);
    logic signed [P_W-1:0] t_ext, prod, thr_q;
    assign t_ext = P_W'(TV);
    assign prod  = norm_ext * t_ext;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   thr_q <= '0;
      else if (en_i) thr_q <= prod >>> SHIFT;
    end
    assign thr_o[gj*P_W +: P_W] = thr_q;
  end
endmodule

// File: rtl/kq_bin.sv
module kq_bin #(
  parameter int BITS    = 3,
  parameter int COORD_W = 8,
  parameter int P_W     = 21
) (
  input  logic [COORD_W-1:0]             coord_i,
  input  logic [((1<<BITS)-1)*P_W-1:0]   thr_i,
  output logic [BITS-1:0]                idx_o
);
  localparam int NT = (1 << BITS) - 1;

  logic signed [P_W-1:0] x_ext;
  assign x_ext = P_W'($signed(coord_i));

  // ties go up: count thresholds not above x
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < NT; j++)
      if (x_ext >= $signed(thr_i[j*P_W +: P_W])) idx_o = idx_o + BITS'(1);
  end
endmodule

// File: rtl/kq_encoder.sv
module kq_encoder
  import kq_pkg::*;
#(
  parameter int DIM     = 16,
  parameter int COORD_W = 8,
  parameter int BITS    = 3,
  parameter int ADDR_W  = 6,
  localparam int SQ_NEED = 2 * COORD_W - 1 + $clog2(DIM),
  localparam int NORM_W  = (SQ_NEED + 1) / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [DIM*COORD_W-1:0]  key_raw_i,
  input  logic [DIM*COORD_W-1:0]  key_rot_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    wr_en_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [NORM_W-1:0]       norm_o,
  output logic [DIM*BITS-1:0]     idx_o
);
  localparam int SQ_W      = 2 * NORM_W;
  localparam int NT        = (1 << BITS) - 1;
  localparam int THR_SHIFT = THR_FRAC + $clog2(DIM) / 2;
  localparam int P_W       = NORM_W + 1 + THR_W;

  kq_state_e               state_q;
  logic                    accept, root_done, busy, emit;
  logic [DIM*COORD_W-1:0]  rot_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [SQ_W-1:0]         sumsq;
  logic [NORM_W-1:0]       root;
  logic [NT*P_W-1:0]       thr;
  logic [DIM*BITS-1:0]     idx_w;
  logic [2*COORD_W-1:0]    sq_w [DIM];

  assign accept = start_i && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);
  assign emit   = (state_q == ST_EMIT);

  for (genvar gi = 0; gi < DIM; gi++) begin : g_sq
    logic signed [2*COORD_W-1:0] c_ext;
    assign c_ext    = (2*COORD_W)'($signed(key_raw_i[gi*COORD_W +: COORD_W]));
    assign sq_w[gi] = c_ext * c_ext;
  end

  always_comb begin
    sumsq = '0;
    for (int i = 0; i < DIM; i++) sumsq = sumsq + SQ_W'(sq_w[i]);
  end

  kq_sqrt #(.IN_W(SQ_W), .OUT_W(NORM_W)) u_sqrt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .rad_i  (sumsq),
    .done_o (root_done),
    .root_o (root)
  );

  kq_thresh_scale #(.BITS(BITS), .NORM_W(NORM_W), .SHIFT(THR_SHIFT), .P_W(P_W)) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SCALE),
    .norm_i (root),
    .thr_o  (thr)
  );

  for (genvar gi = 0; gi < DIM; gi++) begin : g_bin
    kq_bin #(.BITS(BITS), .COORD_W(COORD_W), .P_W(P_W)) u_bin (
      .coord_i (rot_q[gi*COORD_W +: COORD_W]),
      .thr_i   (thr),
      .idx_o   (idx_w[gi*BITS +: BITS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rot_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (accept) begin
                    state_q <= ST_ROOT;
                    rot_q   <= key_rot_i;
                    addr_q  <= addr_i;
                  end
        ST_ROOT:  if (root_done) state_q <= ST_SCALE;
        ST_SCALE: state_q <= ST_EMIT;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o <= 1'b0;
      addr_o  <= '0;
      norm_o  <= '0;
      idx_o   <= '0;
    end else begin
      wr_en_o <= emit;
      if (emit) begin
        addr_o <= addr_q;
        norm_o <= root;
        idx_o  <= idx_w;
      end
    end
  end
endmodule

// File: rtl/kq_encoder_chk.sv
module kq_encoder_chk #(
  parameter int DIM     = 16,
  parameter int COORD_W = 8,
  parameter int BITS    = 3,
  parameter int ADDR_W  = 6,
  parameter int NORM_W  = 10,
  parameter int P_W     = 21
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            start_i,
  input logic                            busy_i,
  input logic                            emit_i,
  input logic [ADDR_W-1:0]               addr_q_i,
  input logic [DIM*COORD_W-1:0]          rot_q_i,
  input logic [((1<<BITS)-1)*P_W-1:0]    thr_i,
  input logic                            wr_en_i,
  input logic [ADDR_W-1:0]               addr_o_i,
  input logic [NORM_W-1:0]               norm_i,
  input logic [DIM*BITS-1:0]             idx_i
);
  localparam int NT  = (1 << BITS) - 1;
  localparam int MID = (1 << (BITS - 1)) - 1;

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  assert_busy_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(addr_q_i));

  assert_hold_between_writes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> ($stable(addr_o_i) && $stable(norm_i) && $stable(idx_i)));

  assert_mid_threshold_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |-> (thr_i[MID*P_W +: P_W] == '0));

  for (genvar gj = 0; gj < NT - 1; gj++) begin : g_ord
    assert_thresholds_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      emit_i |-> ($signed(thr_i[gj*P_W +: P_W]) <= $signed(thr_i[(gj+1)*P_W +: P_W])));
  end

  for (genvar gi = 0; gi < DIM; gi++) begin : g_sign
    assert_index_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |-> (idx_i[gi*BITS + BITS - 1] == !rot_q_i[gi*COORD_W + COORD_W - 1]));
  end
endmodule

bind kq_encoder kq_encoder_chk #(
  .DIM(DIM), .COORD_W(COORD_W), .BITS(BITS), .ADDR_W(ADDR_W), .NORM_W(NORM_W), .P_W(P_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy),
  .emit_i   (emit),
  .addr_q_i (addr_q),
  .rot_q_i  (rot_q),
  .thr_i    (thr),
  .wr_en_i  (wr_en_o),
  .addr_o_i (addr_o),
  .norm_i   (norm_o),
  .idx_i    (idx_o)
);

// File: tb/sim_kq_encoder.sv
module sim_kq_encoder;
  localparam int DIM = 16, W = 8, AW = 6, NW = 10, LAT = NW + 2;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [DIM*W-1:0] raw = '0, rot = '0;
  logic [AW-1:0] addr = '0;
  logic wr3, wr2;
  logic [AW-1:0] a3, a2;
  logic [NW-1:0] n3, n2;
  logic [DIM*3-1:0] i3;
  logic [DIM*2-1:0] i2;

  always #4 clk = ~clk;

  kq_encoder #(.DIM(DIM), .COORD_W(W), .BITS(3), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .key_raw_i(raw), .key_rot_i(rot),
    .addr_i(addr), .wr_en_o(wr3), .addr_o(a3), .norm_o(n3), .idx_o(i3));
  kq_encoder #(.DIM(DIM), .COORD_W(W), .BITS(2), .ADDR_W(AW)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .key_raw_i(raw), .key_rot_i(rot),
    .addr_i(addr), .wr_en_o(wr2), .addr_o(a2), .norm_o(n2), .idx_o(i2));

  typedef struct {
    int              due;
    int              norm;
    logic [DIM*3-1:0] x3;
    logic [DIM*2-1:0] x2;
    logic [AW-1:0]   ad;
    logic [DIM*W-1:0] rt;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int cyc = 0, next_free = 0, total = 0, fails = 0;
  bit running = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int isqrt(input int s);
    int r = 0;
    while ((r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  function automatic int bin_of(input int x, input int norm, input int bits);
    int t3[7] = '{-447, -269, -128, 0, 128, 269, 447};
    int t2[3] = '{-251, 0, 251};
    int n = 0;
    int nt = (bits == 3) ? 7 : 3;
    for (int j = 0; j < nt; j++) begin
      int s = (norm * ((bits == 3) ? t3[j] : t2[j])) >>> 10;
      if (x >= s) n++;
    end
    return n;
  endfunction

  task automatic model(output exp_t e);
    int s = 0;
    for (int i = 0; i < DIM; i++) begin
      int c = $signed(raw[i*W +: W]);
      s += c * c;
    end
    e.norm = isqrt(s);
    e.ad = addr;
    e.rt = rot;
    for (int i = 0; i < DIM; i++) begin
      int x = $signed(rot[i*W +: W]);
      e.x3[i*3 +: 3] = 3'(bin_of(x, e.norm, 3));
      e.x2[i*2 +: 2] = 2'(bin_of(x, e.norm, 2));
    end
  endtask

  // drive at a negedge; accepted on the next edge when idle
  task automatic send(input logic [DIM*W-1:0] r, input logic [DIM*W-1:0] o,
                      input logic [AW-1:0] ad, input bit wait_idle);
    exp_t e;
    if (wait_idle) while (cyc + 1 < next_free) @(negedge clk);
    raw = r; rot = o; addr = ad; start = 1'b1;
    if (cyc + 1 >= next_free) begin
      model(e);
      e.due = cyc + 1 + LAT;
      next_free = e.due + 1;
      q.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    raw = {$urandom, $urandom, $urandom, $urandom};
    rot = {$urandom, $urandom, $urandom, $urandom};
    addr = AW'($urandom);
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        last = q.pop_front();
        chk("R2 write strobe", 64'(wr3), 64'(1));
        chk("R2 address", 64'(a3), 64'(last.ad));
        chk("R3 norm", 64'(n3), 64'(last.norm));
        chk("R4 R5 R6 packed indices", 64'(i3), 64'(last.x3));
        for (int i = 0; i < DIM; i++)
          chk("R8 index sign bit", 64'(i3[i*3+2]), 64'(!last.rt[i*W+W-1]));
        chk("R10 write strobe", 64'(wr2), 64'(1));
        chk("R10 norm", 64'(n2), 64'(last.norm));
        chk("R10 packed indices", 64'(i2), 64'(last.x2));
      end else begin
        chk("R2 R7 no write", 64'(wr3), 64'(0));
        chk("R10 no write", 64'(wr2), 64'(0));
        chk("R9 hold address", 64'(a3), 64'(last.ad));
        chk("R9 hold norm", 64'(n3), 64'(last.norm));
        chk("R9 hold indices", 64'(i3), 64'(last.x3));
        chk("R9 hold indices 2-bit", 64'(i2), 64'(last.x2));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [DIM*W-1:0] r, o;
    last = '{default: '0};
    repeat (3) @(negedge clk);
    // R1: reset values while held and right after release
    chk("R1 reset strobe", 64'(wr3), 64'(0));
    chk("R1 reset addr", 64'(a3), 64'(0));
    chk("R1 reset norm", 64'(n3), 64'(0));
    chk("R1 reset idx", 64'(i3), 64'(0));
    rst_ni = 1'b1;
    running = 1;
    repeat (2) @(negedge clk);

    // zero key: all scaled thresholds zero, every index at top bin (R5 tie)
    send('0, '0, 6'd1, 1);

    // ties around norm 64 (R4, R5)
    r = '0; r[0 +: W] = 8'sd64;
    o = '0;
    begin
      int xs[16] = '{8, 7, -8, -9, 0, -1, 16, 17, 27, 28, -17, -18, -28, -29, 127, -128};
      for (int i = 0; i < DIM; i++) o[i*W +: W] = W'(xs[i]);
    end
    send(r, o, 6'd2, 1);

    // ties for the 2-bit set at norm 64 (R10): thresholds -16, 0, 15
    for (int i = 0; i < DIM; i++) o[i*W +: W] = W'((i % 2) ? 15 : -16) + W'(i / 8);
    send(r, o, 6'd3, 1);

    // full-scale raw key, norm 512 (R3)
    r = {DIM{8'h80}};
    send(r, {$urandom, $urandom, $urandom, $urandom}, 6'd63, 1);

    // start while busy must be ignored (R7)
    send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 6'd10, 1);
    repeat (3) @(negedge clk);
    send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 6'd20, 0);
    repeat (2) @(negedge clk);

    // random keys, back to back and with gaps
    for (int k = 0; k < 30; k++) begin
      o = {$urandom, $urandom, $urandom, $urandom};
      r = (k % 3 == 0) ? o : {$urandom, $urandom, $urandom, $urandom};
      if (k % 4 == 1) for (int i = 0; i < DIM; i++) r[i*W +: W] = r[i*W +: W] >>> 3;
      send(r, o, AW'($urandom), 1);
      if (k % 5 == 2) repeat (k % 7) @(negedge clk);
    end

    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule